// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial memory bus and brings the bus back to a known state. It is used after power-up, or after a command transfer was abandoned partway through and a slave may still be holding SDA low. A single-cycle start pulse launches one of three recovery patterns. The patterns are built from dummy SCL clocks and START conditions. Both lines are open-drain, so each one is driven only by an output enable that pulls it low.

The pace comes from a bit tick that an external clock divider produces. Each phase of a pattern lasts until the next tick. During a dummy clock SDA is always left released, because the slave may be pulling it low with an acknowledge or a zero data bit, and driving it high would cause contention. After the final START the sequencer parks with SCL released and SDA pulled low, so the next normal command can follow. It then pulses done.

Top module: `busrec_seq`

## Requirements
- R1: While reset is asserted, and after it is released, scl_oe, sda_oe, busy and done are all 0.
- R2: mode_sel 2'b00 runs 14 dummy clocks followed by 2 STARTs.
- R3: mode_sel 2'b01 runs 1 START, then 9 dummy clocks, then 1 START.
- R4: mode_sel 2'b10 runs 9 STARTs back to back.
- R5: mode_sel 2'b11 runs exactly the same pattern as 2'b00.
- R6: A dummy clock is one tick with scl_oe=1 and sda_oe=0, then one tick with both at 0. sda_oe is never 1 while scl_oe is 1.
- R7: A START is one tick with both enables at 0 (both lines high), then one tick with scl_oe=0 and sda_oe=1.
- R8: busy is 1 from the cycle after an accepted start until the tick that ends the final phase. done is 1 for exactly the single cycle in which busy first reads 0 again.
- R9: From the done cycle until the next accepted start, scl_oe=0 and sda_oe=1.
- R10: A start pulse while busy is 1 has no effect, including one in the cycle of the final tick. The running pattern and its mode are kept, and no new run begins.
- R11: While busy, the line enables change only on a cycle whose tick input was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-cycle request to run a recovery pattern |
| mode_sel | input | 2 | Pattern select: 00 clocks-then-starts, 01 start-clocks-start, 10 starts only, 11 same as 00 |
| tick | input | 1 | Bit-rate tick from a clock divider; each pattern phase ends on one |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| busy | output | 1 | A pattern is in progress |
| done | output | 1 | One-cycle pulse when a pattern has finished |

## Verification
The tick that ends the last phase and a new start pulse can fall in the same cycle. The ending run still counts as busy at that edge, so the new request has to be discarded, not queued. The bench provokes this by watching the scoreboard queue. When only the final phase is left and a tick is due, it raises start with a different mode for that one cycle. The result is judged at the ports: done must pulse once, busy must stay low afterwards, and SDA must remain parked low, with no new pattern appearing. A second overlap, a start raised in the middle of a run together with a changed mode, is judged by the scoreboard seeing the original phase order through to the end.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [1:0] {
    MODE_CLK_FIRST  = 2'b00,
    MODE_SANDWICH   = 2'b01,
    MODE_START_ONLY = 2'b10,
    MODE_ALIAS      = 2'b11
  } rec_mode_e;

  typedef enum logic {
    EL_CLK   = 1'b0,
    EL_START = 1'b1
  } elem_e;

  localparam int SEG_W = 2;

endpackage

// File: rtl/busrec_plan.sv
module busrec_plan
  import busrec_pkg::*;
#(
  parameter int A_CLKS   = 14,
  parameter int A_STARTS = 2,
  parameter int B_CLKS   = 9,
  parameter int C_STARTS = 9,
  parameter int CW       = 5
) (
  input  logic [1:0]       mode_i,
  input  logic [SEG_W-1:0] seg_i,
  output elem_e            kind_o,
  output logic [CW-1:0]    count_o,
  output logic             last_o
);

  localparam logic [CW-1:0] N_A_CLK   = CW'(A_CLKS);
  localparam logic [CW-1:0] N_A_START = CW'(A_STARTS);
  localparam logic [CW-1:0] N_B_CLK   = CW'(B_CLKS);
  localparam logic [CW-1:0] N_C_START = CW'(C_STARTS);
  localparam logic [CW-1:0] N_ONE     = CW'(1);

  rec_mode_e mode;
  assign mode = rec_mode_e'(mode_i);

  always_comb begin
    kind_o  = EL_START;
    count_o = N_ONE;
    last_o  = 1'b1;
    unique case (mode)
      MODE_SANDWICH: begin
        unique case (seg_i)
          2'd0: begin kind_o = EL_START; count_o = N_ONE;   last_o = 1'b0; end
          2'd1: begin kind_o = EL_CLK;   count_o = N_B_CLK; last_o = 1'b0; end
          default: begin kind_o = EL_START; count_o = N_ONE; last_o = 1'b1; end
        endcase
      end
      MODE_START_ONLY: begin
        kind_o  = EL_START;
        count_o = N_C_START;
        last_o  = 1'b1;
      end
      default: begin
        if (seg_i == '0) begin
          kind_o = EL_CLK;   count_o = N_A_CLK;   last_o = 1'b0;
        end else begin
          kind_o = EL_START; count_o = N_A_START; last_o = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/busrec_step.sv
module busrec_step
  import busrec_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             tick_i,
  input  logic [CW-1:0]    count_i,
  input  logic             last_i,
  output logic [1:0]       eff_mode_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             ph_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [1:0]       mode_q, mode_d;
  logic [SEG_W-1:0] seg_q, seg_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             elem_end;

  assign elem_end = (cnt_q == (count_i - ONE));

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    mode_d = mode_q;
    seg_d  = seg_q;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        mode_d = mode_i;
        seg_d  = '0;
        cnt_d  = '0;
        ph_d   = 1'b0;
      end
    end else if (tick_i) begin
      if (!ph_q) begin
        ph_d = 1'b1;
      end else begin
        ph_d = 1'b0;
        if (elem_end) begin
          cnt_d = '0;
          if (last_i) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            seg_d = seg_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= '0;
      seg_q  <= '0;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      mode_q <= mode_d;
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
    end
  end

  assign eff_mode_o = busy_q ? mode_q : mode_i;
  assign seg_o      = seg_q;
  assign ph_o       = ph_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_busy_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !tick_i) |=> (busy_q && $stable(mode_q) && $stable(seg_q)
                                          && $stable(cnt_q) && $stable(ph_q)));

  p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i) |=> (ph_q == $past(ph_q)) && (seg_q == $past(seg_q))
                            && (cnt_q == $past(cnt_q)) && busy_q);

endmodule

// File: rtl/busrec_pins.sv
module busrec_pins
  import busrec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  busy_i,
  input  logic  done_i,
  input  elem_e kind_i,
  input  logic  ph_i,
  output logic  scl_oe_o,
  output logic  sda_oe_o
);

  logic park_q, park_d;

  always_comb begin
    park_d = park_q;
    if (done_i)      park_d = 1'b1;
    else if (busy_i) park_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) park_q <= 1'b0;
    else        park_q <= park_d;
  end

  // low phase of a dummy clock pulls SCL; second phase of a START pulls SDA
  assign scl_oe_o = busy_i && (kind_i == EL_CLK) && !ph_i;
  assign sda_oe_o = busy_i ? ((kind_i == EL_START) && ph_i) : (park_q || done_i);

  p_sda_free_in_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe_o |-> (!sda_oe_o && busy_i));

  p_park_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (sda_oe_o && !scl_oe_o));

  p_park_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sda_oe_o) && !$past(busy_i) && !busy_i) |-> (sda_oe_o && !scl_oe_o));

endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int A_CLKS   = 14,
  parameter int A_STARTS = 2,
  parameter int B_CLKS   = 9,
  parameter int C_STARTS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode_sel,
  input  logic       tick,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       done
);

  localparam int MAX_AB = (A_CLKS > B_CLKS) ? A_CLKS : B_CLKS;
  localparam int MAX_SC = (C_STARTS > A_STARTS) ? C_STARTS : A_STARTS;
  localparam int MAX_N  = (MAX_AB > MAX_SC) ? MAX_AB : MAX_SC;
  localparam int CW     = $clog2(MAX_N + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic [1:0]       eff_mode;
  logic [SEG_W-1:0] seg;
  logic             ph;
  elem_e            kind;
  logic [CW-1:0]    count;
  logic             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  busrec_step #(.CW(CW)) u_step (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start_i    (start),
    .mode_i     (mode_sel),
    .tick_i     (tick),
    .count_i    (count),
    .last_i     (last),
    .eff_mode_o (eff_mode),
    .seg_o      (seg),
    .ph_o       (ph),
    .busy_o     (busy),
    .done_o     (done)
  );

  busrec_plan #(
    .A_CLKS   (A_CLKS),
    .A_STARTS (A_STARTS),
    .B_CLKS   (B_CLKS),
    .C_STARTS (C_STARTS),
    .CW       (CW)
  ) u_plan (
    .mode_i  (eff_mode),
    .seg_i   (seg),
    .kind_o  (kind),
    .count_o (count),
    .last_o  (last)
  );

  busrec_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .busy_i   (busy),
    .done_i   (done),
    .kind_i   (kind),
    .ph_i     (ph),
    .scl_oe_o (scl_oe),
    .sda_oe_o (sda_oe)
  );

endmodule

// File: tb/tb_busrec_seq.sv
module tb_busrec_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] mode_sel;
  logic       tick;
  logic       scl_oe, sda_oe, busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  logic finished = 1'b0;
  logic tick_en  = 1'b0;
  logic mon_en   = 1'b0;
  string cur_tag = "R2";
  logic [1:0] exp_q[$];

  always #2 clk = ~clk;

  busrec_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel), .tick(tick),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // tick every third cycle, driven just after the rising edge
  initial begin
    tick = 1'b0;
    forever begin
      for (int i = 0; i < 3; i++) begin
        @(posedge clk); #1;
        tick = tick_en && (i == 2);
      end
    end
  end

  // monitor: each tick seen while busy closes one phase of the pattern
  always @(negedge clk) begin
    if (mon_en && busy && tick) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_tag, " extra phase"}, {scl_oe, sda_oe}, -1);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        // R6 (dummy clock phases) / R7 (START phases) within the mode pattern
        chk({scl_oe, sda_oe} == e, {cur_tag, "/R6/R7 phase"}, {scl_oe, sda_oe}, e);
      end
    end
  end

  task automatic push_clks(input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(2'b10); exp_q.push_back(2'b00); end
  endtask

  task automatic push_starts(input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(2'b00); exp_q.push_back(2'b01); end
  endtask

  task automatic push_mode(input logic [1:0] m);
    case (m)
      2'b01:   begin push_starts(1); push_clks(9); push_starts(1); end
      2'b10:   push_starts(9);
      default: begin push_clks(14); push_starts(2); end
    endcase
  endtask

  task automatic pulse_start(input logic [1:0] m);
    @(posedge clk); #1;
    start = 1'b1; mode_sel = m;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int guard = 0;
    @(negedge clk);
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk(done, {tag, " R8 done seen"}, done, 1);
    chk(!busy, {tag, " R8 busy low at done"}, busy, 0);
    chk(exp_q.size() == 0, {tag, " phases left at done"}, exp_q.size(), 0);
    chk(sda_oe && !scl_oe, {tag, " R9 park at done"}, {scl_oe, sda_oe}, 1);
    @(negedge clk);
    chk(!done, {tag, " R8 done single cycle"}, done, 0);
    repeat (5) @(negedge clk);
    chk(sda_oe && !scl_oe && !busy, {tag, " R9 park held"}, {busy, scl_oe, sda_oe}, 1);
  endtask

  task automatic run_mode(input logic [1:0] m, input string tag);
    cur_tag = tag;
    push_mode(m);
    pulse_start(m);
    @(negedge clk);
    chk(busy, {tag, " R8 busy after start"}, busy, 1);
    wait_done(tag);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, busy, done} == 4'b0, "R1 in reset", {scl_oe, sda_oe, busy, done}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({scl_oe, sda_oe, busy, done} == 4'b0, "R1 after reset", {scl_oe, sda_oe, busy, done}, 0);
    tick_en = 1'b1; mon_en = 1'b1;

    run_mode(2'b00, "R2");
    run_mode(2'b01, "R3");
    run_mode(2'b10, "R4");
    run_mode(2'b11, "R5");

    // R11: stall the tick in the middle of a run; pattern must resume intact
    cur_tag = "R11";
    push_mode(2'b01);
    pulse_start(2'b01);
    repeat (10) @(posedge clk);
    tick_en = 1'b0;
    @(negedge clk);
    begin
      logic [1:0] held;
      held = {scl_oe, sda_oe};
      repeat (12) @(negedge clk);
      chk({scl_oe, sda_oe} == held && busy, "R11 no change without tick", {scl_oe, sda_oe}, held);
    end
    tick_en = 1'b1;
    wait_done("R11");

    // R10: start with a different mode in the middle of a run
    cur_tag = "R10";
    push_mode(2'b00);
    pulse_start(2'b00);
    repeat (7) @(posedge clk);
    #1; start = 1'b1; mode_sel = 2'b10;
    @(posedge clk); #1; start = 1'b0;
    wait_done("R10 mid");

    // R10: start in the same cycle as the final tick
    cur_tag = "R10";
    push_mode(2'b10);
    pulse_start(2'b10);
    begin
      int guard = 0;
      logic hit = 1'b0;
      while (!hit && guard < 2000) begin
        @(posedge clk); #1.5;
        guard++;
        if (tick && exp_q.size() == 1) begin
          start = 1'b1; mode_sel = 2'b01; hit = 1'b1;
        end
      end
      chk(hit, "R10 collision provoked", hit, 1);
      @(posedge clk); #1; start = 1'b0;
      chk(done && !busy, "R10 done on collision", {busy, done}, 1);
    end
    repeat (12) @(negedge clk);
    chk(!busy && sda_oe && !scl_oe, "R10 no restart after collision", {busy, scl_oe, sda_oe}, 1);
    chk(exp_q.size() == 0, "R10 no extra phases", exp_q.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule